// File: doc/BRIEF.md
# Configurable Parallel-Prefix Adder

This block is a purely combinational two-operand binary adder with a carry input. Its carry logic is a parallel-prefix network over per-bit (generate, propagate) pairs. Each prefix cell merges a more significant span with the less significant span directly below it. After the last level, position i of the network holds the pair for bits 0 through i, and its generate term is the carry into bit i+1. The per-bit pair logic and the final sum XOR are part of the block. The carry input enters the network as a generate contribution below bit 0: it is merged into the bit-0 generate term before the first level.

An elaboration parameter selects the shape of the network, so a designer can trade cell count against logic depth without changing any port. There are three shapes. The sparse shape first pairs spans upward and then fills in the missing prefixes on the way back down. The dense shape combines every position with the position a power of two below it at each level. The hybrid shape uses a sparse first and last level around a dense core. All three produce the same sum and carry-out for every input.

Top module: `prefix_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of op_a + op_b + c_in, with both operands unsigned.
- R2: `c_out` equals bit 16 of the 17-bit result of op_a + op_b + c_in.
- R3: With both operands zero, `sum_o` equals c_in (value 0 or 1) and `c_out` is 0. This is also the output state while the bench holds its inputs at zero after reset.
- R4: When every bit propagates (op_a XOR op_b is all ones and op_a AND op_b is zero), c_in=0 gives sum 16'hFFFF with carry-out 0, and c_in=1 gives sum 0 with carry-out 1.
- R5: A single generate at bit j (op_a = 1<<j, op_b = 16'hFFFF<<j, c_in=0), followed by propagate in every bit above j, gives sum 0 and carry-out 1 for every j from 0 to 15.
- R6: A single generate at bit j with kill in every other bit (op_a = op_b = 1<<j) gives sum 1<<(j+1) for j<15. For j=15 it gives sum 0 and carry-out 1.
- R7: Parameter `TOPO` selects the network shape: TOPO_SPARSE (value 0) with 6 levels and 26 cells at 16 bits, TOPO_DENSE (value 1) with 4 levels and 49 cells, and TOPO_HYBRID (value 2) with 5 levels and 32 cells. A width that is not a power of two of at least 4, or a cell or level count that differs from these closed forms, stops elaboration.
- R8: For identical inputs, all three shapes give bit-identical `sum_o` and `c_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand, unsigned |
| op_b | input | 16 | Second operand, unsigned |
| c_in | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| c_out | output | 1 | Carry out of the most significant bit |

## Verification
The hardest situation to reach from the ports is a carry that has to travel through every level of the network: it is generated in one low bit and propagated by all bits above. Random operands almost never produce this. The stimulus therefore sweeps a single generate position with all-propagate above it, a single generate position with kill everywhere else, and the all-propagate word with carry-in set. Together these force the longest prefix spans in each shape to decide the result. One set of inputs drives a sparse, a dense and a hybrid instance, and each one's outputs are compared against an arithmetic reference and against the others.

// File: rtl/prefix_pkg.sv
package prefix_pkg;

   typedef enum int {
      TOPO_SPARSE = 0,
      TOPO_DENSE  = 1,
      TOPO_HYBRID = 2
   } topo_e;

   // number of prefix levels for a shape over 2**k positions
   function automatic int topo_levels(topo_e t, int k);
      case (t)
         TOPO_SPARSE: return 2 * k - 2;
         TOPO_DENSE:  return k;
         default:     return k + 1;
      endcase
   endfunction

   // index of the lower span merged into position i at level lvl, or -1 to pass through
   function automatic int lower_index(topo_e t, int k, int lvl, int i);
      int stride;
      int half;
      int dn;
      case (t)
         TOPO_DENSE: begin
            stride = 1 << (lvl - 1);
            if (i >= stride) return i - stride;
            return -1;
         end
         TOPO_SPARSE: begin
            if (lvl <= k) begin
               stride = 1 << lvl;
               if (((i + 1) % stride) == 0) return i - (stride / 2);
            end
            dn = 2 * k - 2 - lvl;
            if (dn >= 0 && dn <= k - 2) begin
               half = 1 << dn;
               if (((i + 1) % (2 * half)) == half && i >= 2 * half) return i - half;
            end
            return -1;
         end
         default: begin
            if (lvl == 1) begin
               if ((i % 2) == 1) return i - 1;
               return -1;
            end
            if (lvl == k + 1) begin
               if ((i % 2) == 0 && i >= 2) return i - 1;
               return -1;
            end
            stride = 1 << (lvl - 1);
            if ((i % 2) == 1 && i >= stride + 1) return i - stride;
            return -1;
         end
      endcase
   endfunction

   // cells actually placed by the rules above
   function automatic int topo_cells(topo_e t, int k);
      int n;
      n = 0;
      for (int lv = 1; lv <= topo_levels(t, k); lv++)
         for (int i = 0; i < (1 << k); i++)
            if (lower_index(t, k, lv, i) >= 0) n++;
      return n;
   endfunction

   // deepest level that holds at least one cell
   function automatic int topo_depth(topo_e t, int k);
      int d;
      d = 0;
      for (int lv = 1; lv <= topo_levels(t, k); lv++)
         for (int i = 0; i < (1 << k); i++)
            if (lower_index(t, k, lv, i) >= 0) d = lv;
      return d;
   endfunction

   // closed-form cell budget for each shape
   function automatic int expected_cells(topo_e t, int k);
      int n;
      n = 1 << k;
      case (t)
         TOPO_SPARSE: return 2 * n - 2 - k;
         TOPO_DENSE:  return n * k - n + 1;
         default:     return (n * k) / 2;
      endcase
   endfunction

endpackage

// File: rtl/pp_pair_gen.sv
module pp_pair_gen #(
   parameter int W = 16
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic [W-1:0] gen_o,
   output logic [W-1:0] prop_o
);

   logic [W-1:0] gen_raw;

   assign gen_raw = a_i & b_i;
   assign prop_o  = a_i ^ b_i;

   // carry-in acts as a generate below bit 0, folded into bit 0
   always_comb begin
      gen_o    = gen_raw;
      gen_o[0] = gen_raw[0] | (prop_o[0] & cin_i);
   end

endmodule

// File: rtl/pp_cell.sv
module pp_cell (
   input  logic g_hi,
   input  logic p_hi,
   input  logic g_lo,
   input  logic p_lo,
   output logic g_o,
   output logic p_o
);

   // higher span wins unless it passes the lower span's carry through
   assign g_o = g_hi | (g_lo & p_hi);
   assign p_o = p_lo & p_hi;

endmodule

// File: rtl/pp_tree.sv
module pp_tree #(
   parameter int                 W    = 16,
   parameter prefix_pkg::topo_e  TOPO = prefix_pkg::TOPO_SPARSE
) (
   input  logic [W-1:0] gen_i,
   input  logic [W-1:0] prop_i,
   output logic [W-1:0] grp_gen_o
);

   localparam int K  = $clog2(W);
   localparam int NL = prefix_pkg::topo_levels(TOPO, K);
   localparam int NC = prefix_pkg::topo_cells(TOPO, K);
   localparam int NE = prefix_pkg::expected_cells(TOPO, K);
   localparam int ND = prefix_pkg::topo_depth(TOPO, K);

   // R7: elaboration-time legality of width and shape
   if (W != (1 << K) || K < 2) begin : g_bad_width
      $error("pp_tree: width must be a power of two of at least 4");
   end
   if (NC != NE) begin : g_bad_cells
      $error("pp_tree: cell count does not match the selected shape");
   end
   if (ND != NL) begin : g_bad_levels
      $error("pp_tree: level count does not match the selected shape");
   end

   logic [W-1:0] gl [0:NL];
   logic [W-1:0] pl [0:NL];

   assign gl[0] = gen_i;
   assign pl[0] = prop_i;

   for (genvar lv = 1; lv <= NL; lv++) begin : g_level
      for (genvar i = 0; i < W; i++) begin : g_pos
         localparam int LO = prefix_pkg::lower_index(TOPO, K, lv, i);
         if (LO >= 0) begin : g_cell
            pp_cell u_cell (
               .g_hi (gl[lv-1][i]),
               .p_hi (pl[lv-1][i]),
               .g_lo (gl[lv-1][LO]),
               .p_lo (pl[lv-1][LO]),
               .g_o  (gl[lv][i]),
               .p_o  (pl[lv][i])
            );
         end else begin : g_pass
            assign gl[lv][i] = gl[lv-1][i];
            assign pl[lv][i] = pl[lv-1][i];
         end
      end
   end

   assign grp_gen_o = gl[NL];

   // R4: every final span [0,i] propagates exactly when all its bits do
   logic span_run;
   always_comb begin
      span_run = 1'b1;
      for (int i = 0; i < W; i++) begin
         span_run = span_run & prop_i[i];
         a_r4_span_propagate: assert (pl[NL][i] == span_run)
            else $error("a_r4_span_propagate: span propagate wrong at %0d", i);
      end
   end

endmodule

// File: rtl/pp_sum.sv
module pp_sum #(
   parameter int W = 16
) (
   input  logic [W-1:0] prop_i,
   input  logic [W-1:0] grp_gen_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o
);

   logic [W-1:0] carry;

   // carry into bit i is the group generate of span [0,i-1]
   assign carry  = {grp_gen_i[W-2:0], cin_i};
   assign sum_o  = prop_i ^ carry;
   assign cout_o = grp_gen_i[W-1];

endmodule

// File: rtl/prefix_adder.sv
module prefix_adder #(
   parameter int                 W    = 16,
   parameter prefix_pkg::topo_e  TOPO = prefix_pkg::TOPO_SPARSE
) (
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  logic         c_in,
   output logic [W-1:0] sum_o,
   output logic         c_out
);

   logic [W-1:0] gen_bits;
   logic [W-1:0] prop_bits;
   logic [W-1:0] grp_gen;

   pp_pair_gen #(.W(W)) u_pairs (
      .a_i    (op_a),
      .b_i    (op_b),
      .cin_i  (c_in),
      .gen_o  (gen_bits),
      .prop_o (prop_bits)
   );

   pp_tree #(.W(W), .TOPO(TOPO)) u_tree (
      .gen_i     (gen_bits),
      .prop_i    (prop_bits),
      .grp_gen_o (grp_gen)
   );

   pp_sum #(.W(W)) u_sum (
      .prop_i    (prop_bits),
      .grp_gen_i (grp_gen),
      .cin_i     (c_in),
      .sum_o     (sum_o),
      .cout_o    (c_out)
   );

   // arithmetic cross-check against the prefix result
   logic [W:0] ref_total;
   always_comb begin
      ref_total = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, c_in};
      a_r1_sum_value: assert (sum_o == ref_total[W-1:0])
         else $error("a_r1_sum_value: sum mismatch");
      a_r2_carry_out: assert (c_out == ref_total[W])
         else $error("a_r2_carry_out: carry-out mismatch");
      if (op_a == '0 && op_b == '0) begin
         a_r3_cin_alone: assert (sum_o == {{(W-1){1'b0}}, c_in} && !c_out)
            else $error("a_r3_cin_alone: carry-in not passed to sum");
      end
      if ((op_a ^ op_b) == '1 && (op_a & op_b) == '0) begin
         a_r4_full_chain: assert (c_out == c_in && sum_o == {W{~c_in}})
            else $error("a_r4_full_chain: full-length propagate wrong");
      end
   end

endmodule

// File: tb/tb_prefix_adder.sv
module tb_prefix_adder;

   localparam int W = 16;

   logic         clk;
   logic         rst;
   logic [W-1:0] op_a;
   logic [W-1:0] op_b;
   logic         c_in;
   logic [W-1:0] sum_s, sum_d, sum_h;
   logic         cout_s, cout_d, cout_h;

   int checks = 0;
   int errors = 0;

   logic [W:0] exp_q [$];
   string      tag_q [$];

   prefix_adder #(.W(W), .TOPO(prefix_pkg::TOPO_SPARSE)) dut (
      .op_a (op_a), .op_b (op_b), .c_in (c_in), .sum_o (sum_s), .c_out (cout_s)
   );
   prefix_adder #(.W(W), .TOPO(prefix_pkg::TOPO_DENSE)) dut_dense (
      .op_a (op_a), .op_b (op_b), .c_in (c_in), .sum_o (sum_d), .c_out (cout_d)
   );
   prefix_adder #(.W(W), .TOPO(prefix_pkg::TOPO_HYBRID)) dut_hybrid (
      .op_a (op_a), .op_b (op_b), .c_in (c_in), .sum_o (sum_h), .c_out (cout_h)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;

   task automatic chk(input string tag, input logic [W:0] got, input logic [W:0] want);
      checks++;
      if (got !== want) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, want);
      end
   endtask

   // driver: apply one vector after a rising edge and queue its expected result
   task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y,
                        input logic ci, input string tag);
      @(posedge clk);
      #1;
      op_a = x;
      op_b = y;
      c_in = ci;
      exp_q.push_back({1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci});
      tag_q.push_back(tag);
   endtask

   // monitor: pop and compare at the falling edge, when outputs have settled
   initial begin
      forever begin
         @(negedge clk);
         if (!rst && exp_q.size() > 0) begin
            logic [W:0] want;
            string      tag;
            want = exp_q.pop_front();
            tag  = tag_q.pop_front();
            chk({tag, " sparse"}, {cout_s, sum_s}, want);
            chk("R8 dense vs sparse", {cout_d, sum_d}, {cout_s, sum_s});
            chk("R8 hybrid vs sparse", {cout_h, sum_h}, {cout_s, sum_s});
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst  = 1'b1;
      op_a = '0;
      op_b = '0;
      c_in = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;

      drive(16'h0000, 16'h0000, 1'b0, "R3 idle after reset");
      drive(16'h0000, 16'h0000, 1'b1, "R3 carry-in alone");
      drive(16'hAAAA, 16'h5555, 1'b0, "R4 propagate cin0");
      drive(16'hAAAA, 16'h5555, 1'b1, "R4 propagate cin1");
      drive(16'hFFFF, 16'h0000, 1'b1, "R4 ones plus cin");
      drive(16'h0F0F, 16'hF0F0, 1'b1, "R4 mixed propagate");
      drive(16'hFFFF, 16'hFFFF, 1'b1, "R2 max operands");
      drive(16'h8000, 16'h8000, 1'b0, "R2 top generate");
      drive(16'h00FF, 16'h0001, 1'b0, "R1 low ripple");
      drive(16'h0001, 16'h00FF, 1'b0, "R1 operand swap");

      for (int j = 0; j < W; j++)
         drive(16'(1) << j, 16'hFFFF << j, 1'b0, "R5 single generate then propagate");
      for (int j = 0; j < W; j++)
         drive(16'(1) << j, 16'(1) << j, 1'b0, "R6 single generate then kill");
      for (int j = 0; j < W; j++)
         drive(16'(1) << j, ~(16'(1) << j), 1'b1, "R5 cin through one gap");

      for (int n = 0; n < 300; n++)
         drive(16'($urandom), 16'($urandom), 1'($urandom), "R1 R2 random");

      repeat (3) @(posedge clk);
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R1 drain: got %0d pending expected 0", exp_q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule